// File: doc/BRIEF.md
# Timer Output Emergency-Stop Pin Controller

This block drives one shared I/O pad. The pad can serve as a plain output port, a plain input port, an external interrupt input, or the output of a timer waveform. Three configuration bits choose among these roles. The mode bit picks port versus alternate function. The function bit picks interrupt versus timer. The direction bit sets the port direction. The block drives the pad value and the tristate enable. In interrupt mode it also passes the pad level to an interrupt line.

A separate asynchronous stop pin acts as a safety shut-off for the timer output. The stop pin first passes through a two-flop synchronizer. Its edges are then qualified by a two-bit edge-select field. If the stop-enable bit is set and a qualifying edge arrives while the pad is in timer mode, a stop condition is latched and the pad goes high-impedance. The stop condition stays in force until software writes 0 to the stop-enable bit. The edge-select field is protected while the timer runs. A write to it during that time is dropped and raises a sticky error flag.

Top module: `tmr_pin_stop_ctrl`

## Requirements
- R1: The 8-bit control register resets to 0x00. Bit 0 holds stop-enable, and bits 7..1 always read 0. A byte write (ctl_bit_wr_i=0) loads bit 0 from ctl_wdata_i[0]. A single-bit write (ctl_bit_wr_i=1) changes bit 0 only when ctl_bit_sel_i is 0, and it takes its value from ctl_wdata_i[0].
- R2: While stop-enable is 0, stop-pin edges have no effect, and the timer-mode pad stays driven (pad_oe_o=1).
- R3: With stop-enable at 1, suppose a qualifying stop-pin edge is applied before rising clock edge k while the pad is in timer mode. Then pad_oe_o falls after rising edge k+2 and stays 1 before that.
- R4: A latched stop condition is cleared only by writing 0 to stop-enable. Further edges, changes of pad mode and writes of 1 leave it set. After the clearing write, pad_oe_o is 1 in timer mode.
- R5: With mode bit 0, direction 0 gives pad_oe_o=1 and pad_o=port_data_i. Direction 1 gives pad_oe_o=0.
- R6: With mode bit 1 and function bit 0, pad_oe_o=0 and irq_o follows pad_i. In every other mode, irq_o is 0.
- R7: With mode bit 1 and function bit 1, pad_o follows tmr_wave_i. pad_oe_o is 1 unless the stop condition is latched.
- R8: The edge-select field selects which stop-pin edges qualify: 00 falling, 01 rising, 10 none, 11 both.
- R9: The edge-select field resets to 00 and the error flag resets to 0. An edge-select write while tmr_run_i=1 is dropped and sets esel_err_o. The flag stays set until reset.
- R10: Writing 1 to stop-enable does not latch a stop by itself. An edge that arrives while the pad is not in timer mode latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 1 | Level sensed on the pad |
| stop_pin_i | input | 1 | Asynchronous stop request pin |
| tmr_wave_i | input | 1 | Timer waveform to drive out |
| port_data_i | input | 1 | Port output data |
| mode_ctl_i | input | 1 | 0 port, 1 alternate function |
| func_ctl_i | input | 1 | Alternate function: 0 interrupt, 1 timer |
| dir_i | input | 1 | Port direction: 0 output, 1 input |
| tmr_run_i | input | 1 | Timer running flag |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_bit_wr_i | input | 1 | 1 selects a single-bit write |
| ctl_bit_sel_i | input | 3 | Bit index for single-bit writes |
| ctl_wdata_i | input | 8 | Control write data |
| esel_wr_i | input | 1 | Edge-select write strobe |
| esel_wdata_i | input | 2 | Edge-select write data |
| ctl_rdata_o | output | 8 | Control register read value |
| esel_o | output | 2 | Current edge-select field |
| esel_err_o | output | 1 | Sticky protected-write error |
| pad_o | output | 1 | Pad output value |
| pad_oe_o | output | 1 | Pad output buffer enable |
| irq_o | output | 1 | Routed interrupt input |

## Verification
The pad mux is combinational, so pad_o, pad_oe_o and irq_o are checked one time unit after the inputs change at a falling clock edge. Register writes are presented at a falling edge and sampled at the next falling edge, one rising edge later. A stop-pin change goes through two synchronizer flops and the latch, so pad_oe_o is sampled after the second falling edge, where it must still be high, and again after the third, where it must have dropped. Random mode and data patterns are checked against a bench model, and directed sequences cover each edge-select code, protected writes and the ways the stop condition is cleared.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int CTL_W  = 8;
    localparam int SEL_W  = $clog2(CTL_W);
    localparam int ESEL_W = 2;

    typedef enum logic [ESEL_W-1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        PIN_PORT_OUT,
        PIN_PORT_IN,
        PIN_IRQ_IN,
        PIN_TMR_OUT
    } pin_mode_e;

    typedef struct packed {
        logic mode;
        logic func;
        logic dir;
    } pin_cfg_t;

    typedef struct packed {
        logic val;
        logic oe;
        logic irq;
    } pad_drv_t;

    typedef struct packed {
        logic      en;
        logic      latched;
        edge_sel_e esel;
        logic      err;
    } ctl_state_t;

    function automatic pin_mode_e decode_mode(pin_cfg_t c);
        pin_mode_e m;
        if (!c.mode)      m = c.dir ? PIN_PORT_IN : PIN_PORT_OUT;
        else if (!c.func) m = PIN_IRQ_IN;
        else              m = PIN_TMR_OUT;
        return m;
    endfunction

    function automatic logic edge_hit(edge_sel_e s, logic cur, logic prev);
        logic r;
        case (s)
            EDGE_FALL: r = prev & ~cur;
            EDGE_RISE: r = ~prev & cur;
            EDGE_BOTH: r = prev ^ cur;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tps_stop_sync.sv
module tps_stop_sync
    import tps_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  edge_sel_e esel_i,
    output logic      evt_o
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_i};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_i;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[TOP];
    end

    assign evt_o = edge_hit(esel_i, chain[TOP], prev);

    // R8: the "no edge" code never yields an event
    p_none_code_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (esel_i == EDGE_NONE) |-> !evt_o);

    // R8: an event only follows a change of the synchronized level
    p_evt_on_change_r8: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> (chain[TOP] != prev));

endmodule

// File: rtl/tps_ctl_regs.sv
module tps_ctl_regs
    import tps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             bit_wr_i,
    input  logic [SEL_W-1:0] bit_sel_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             esel_wr_i,
    input  edge_sel_e        esel_wdata_i,
    input  logic             tmr_run_i,
    input  logic             stop_evt_i,
    input  logic             tmr_mode_i,
    output logic [CTL_W-1:0] rdata_o,
    output ctl_state_t       st_o
);

    ctl_state_t st_q, st_d;
    logic       en_hit;
    logic       en_clear;

    assign en_hit   = wr_i && (!bit_wr_i || (bit_sel_i == '0));
    assign en_clear = en_hit && !wdata_i[0];

    always_comb begin
        st_d = st_q;
        if (en_hit) st_d.en = wdata_i[0];
        if (en_clear)
            st_d.latched = 1'b0;
        else if (st_q.en && stop_evt_i && tmr_mode_i)
            st_d.latched = 1'b1;
        if (esel_wr_i) begin
            if (tmr_run_i) st_d.err  = 1'b1;
            else           st_d.esel = esel_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en      <= 1'b0;
            st_q.latched <= 1'b0;
            st_q.esel    <= EDGE_FALL;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = {{(CTL_W-1){1'b0}}, st_q.en};
    assign st_o    = st_q;

    // R1: reset leaves the register cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rdata_o == '0));

    // R2: without stop-enable there is never a latched stop
    p_disabled_no_latch_r2: assert property (@(posedge clk) disable iff (rst)
        !st_q.en |-> !st_q.latched);

    // R4: latch holds unless a zero is written to stop-enable
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.latched && !en_clear) |=> st_q.latched);

    // R9: protected write leaves edge-select unchanged
    p_esel_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (esel_wr_i && tmr_run_i) |=> $stable(st_q.esel));

    // R9: error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.err |=> st_q.err);

    // R10: a stop only latches when enable was already set and an event came
    p_no_self_set_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.latched) |-> ($past(st_q.en) && $past(stop_evt_i) && $past(tmr_mode_i)));

endmodule

// File: rtl/tps_pin_mux.sv
module tps_pin_mux
    import tps_pkg::*;
(
    input  pin_cfg_t cfg_i,
    input  logic     latched_i,
    input  logic     tmr_wave_i,
    input  logic     port_data_i,
    input  logic     pad_i,
    output pad_drv_t drv_o
);

    pin_mode_e mode;

    assign mode = decode_mode(cfg_i);

    always_comb begin
        drv_o = '0;
        unique case (mode)
            PIN_PORT_OUT: begin
                drv_o.val = port_data_i;
                drv_o.oe  = 1'b1;
            end
            PIN_PORT_IN: begin
                drv_o.oe  = 1'b0;
            end
            PIN_IRQ_IN: begin
                drv_o.irq = pad_i;
            end
            PIN_TMR_OUT: begin
                drv_o.val = tmr_wave_i;
                drv_o.oe  = ~latched_i;
            end
            default: drv_o = '0;
        endcase
    end

endmodule

// File: rtl/tmr_pin_stop_ctrl.sv
module tmr_pin_stop_ctrl
    import tps_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pad_i,
    input  logic             stop_pin_i,
    input  logic             tmr_wave_i,
    input  logic             port_data_i,
    input  logic             mode_ctl_i,
    input  logic             func_ctl_i,
    input  logic             dir_i,
    input  logic             tmr_run_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_bit_wr_i,
    input  logic [SEL_W-1:0] ctl_bit_sel_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    input  logic             esel_wr_i,
    input  logic [ESEL_W-1:0] esel_wdata_i,
    output logic [CTL_W-1:0] ctl_rdata_o,
    output logic [ESEL_W-1:0] esel_o,
    output logic             esel_err_o,
    output logic             pad_o,
    output logic             pad_oe_o,
    output logic             irq_o
);

    ctl_state_t st;
    pin_cfg_t   cfg;
    pad_drv_t   drv;
    logic       stop_evt;
    logic       tmr_mode;

    assign cfg      = '{mode: mode_ctl_i, func: func_ctl_i, dir: dir_i};
    assign tmr_mode = (decode_mode(cfg) == PIN_TMR_OUT);

    tps_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (stop_pin_i),
        .esel_i (st.esel),
        .evt_o  (stop_evt)
    );

    tps_ctl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (ctl_wr_i),
        .bit_wr_i     (ctl_bit_wr_i),
        .bit_sel_i    (ctl_bit_sel_i),
        .wdata_i      (ctl_wdata_i),
        .esel_wr_i    (esel_wr_i),
        .esel_wdata_i (edge_sel_e'(esel_wdata_i)),
        .tmr_run_i    (tmr_run_i),
        .stop_evt_i   (stop_evt),
        .tmr_mode_i   (tmr_mode),
        .rdata_o      (ctl_rdata_o),
        .st_o         (st)
    );

    tps_pin_mux u_mux (
        .cfg_i       (cfg),
        .latched_i   (st.latched),
        .tmr_wave_i  (tmr_wave_i),
        .port_data_i (port_data_i),
        .pad_i       (pad_i),
        .drv_o       (drv)
    );

    assign pad_o      = drv.val;
    assign pad_oe_o   = drv.oe;
    assign irq_o      = drv.irq;
    assign esel_o     = st.esel;
    assign esel_err_o = st.err;

    // R7: timer mode without a latched stop keeps the buffer driven
    p_timer_oe_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_ctl_i && func_ctl_i && !st.latched) |-> pad_oe_o);

    // R2: stop-enable clear means the timer pad never floats
    p_stop_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (tmr_mode && ctl_rdata_o[0] == 1'b0) |-> pad_oe_o);

endmodule

// File: tb/tmr_pin_stop_ctrl_tb_top.sv
module tmr_pin_stop_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pad_i = 0, stop_pin_i = 0, tmr_wave_i = 0, port_data_i = 0;
    logic       mode_ctl_i = 0, func_ctl_i = 0, dir_i = 0, tmr_run_i = 0;
    logic       ctl_wr_i = 0, ctl_bit_wr_i = 0;
    logic [2:0] ctl_bit_sel_i = 0;
    logic [7:0] ctl_wdata_i = 0;
    logic       esel_wr_i = 0;
    logic [1:0] esel_wdata_i = 0;
    logic [7:0] ctl_rdata_o;
    logic [1:0] esel_o;
    logic       esel_err_o, pad_o, pad_oe_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pin_stop_ctrl dut_i (
        .clk(clk), .rst(rst), .pad_i(pad_i), .stop_pin_i(stop_pin_i),
        .tmr_wave_i(tmr_wave_i), .port_data_i(port_data_i),
        .mode_ctl_i(mode_ctl_i), .func_ctl_i(func_ctl_i), .dir_i(dir_i),
        .tmr_run_i(tmr_run_i), .ctl_wr_i(ctl_wr_i), .ctl_bit_wr_i(ctl_bit_wr_i),
        .ctl_bit_sel_i(ctl_bit_sel_i), .ctl_wdata_i(ctl_wdata_i),
        .esel_wr_i(esel_wr_i), .esel_wdata_i(esel_wdata_i),
        .ctl_rdata_o(ctl_rdata_o), .esel_o(esel_o), .esel_err_o(esel_err_o),
        .pad_o(pad_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_pad(logic m, logic f, logic d, logic lat,
                                           logic wave, logic pdat, logic pin);
        // returns {val, oe, irq}
        if (!m)      return d ? 3'b000 : {pdat, 1'b1, 1'b0};
        else if (!f) return {2'b00, pin};
        else         return {wave, ~lat, 1'b0};
    endfunction

    task automatic ctl_write(input logic bitw, input logic [2:0] sel, input logic [7:0] d);
        ctl_wr_i = 1; ctl_bit_wr_i = bitw; ctl_bit_sel_i = sel; ctl_wdata_i = d;
        @(negedge clk);
        ctl_wr_i = 0; ctl_bit_wr_i = 0;
    endtask

    task automatic esel_write(input logic [1:0] d);
        esel_wr_i = 1; esel_wdata_i = d;
        @(negedge clk);
        esel_wr_i = 0;
    endtask

    task automatic set_stop(input logic v);
        stop_pin_i = v;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic clear_stop();
        ctl_write(0, 0, 8'h00);
        ctl_write(0, 0, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;

        // R1 / R9 reset state
        check("R1 reset ctl", ctl_rdata_o, 8'h00);
        check("R9 reset esel", {6'b0, esel_o}, 8'h00);
        check("R9 reset err", {7'b0, esel_err_o}, 8'h00);

        // R5 R6 R7: random pad patterns with stop-enable cleared
        for (int i = 0; i < 200; i++) begin
            logic [2:0] e;
            {mode_ctl_i, func_ctl_i, dir_i, pad_i, tmr_wave_i, port_data_i} = 6'($urandom);
            #1;
            e = exp_pad(mode_ctl_i, func_ctl_i, dir_i, 1'b0, tmr_wave_i, port_data_i, pad_i);
            if (!mode_ctl_i) check("R5 port pad", {5'b0, pad_o, pad_oe_o, irq_o}, {5'b0, e});
            else if (!func_ctl_i) check("R6 irq pad", {5'b0, pad_o, pad_oe_o, irq_o}, {5'b0, e});
            else check("R7 timer pad", {5'b0, pad_o, pad_oe_o, irq_o}, {5'b0, e});
            @(negedge clk);
        end

        // R1 write forms
        ctl_write(0, 0, 8'hFF); #1; check("R1 byte ff", ctl_rdata_o, 8'h01);
        ctl_write(0, 5, 8'hFE); #1; check("R1 byte fe", ctl_rdata_o, 8'h00);
        ctl_write(1, 3, 8'h01); #1; check("R1 bit3 ignored", ctl_rdata_o, 8'h00);
        ctl_write(1, 0, 8'h01); #1; check("R1 bit0 set", ctl_rdata_o, 8'h01);
        ctl_write(1, 0, 8'h00); #1; check("R1 bit0 clr", ctl_rdata_o, 8'h00);

        // R2: edges ignored when disabled, timer mode
        mode_ctl_i = 1; func_ctl_i = 1; tmr_wave_i = 1;
        set_stop(1); set_stop(0);
        check("R2 oe stays", {7'b0, pad_oe_o}, 8'h01);

        // R10: enabling alone does not stop
        esel_write(2'b01);
        ctl_write(0, 0, 8'h01); #1;
        check("R10 enable no stop", {7'b0, pad_oe_o}, 8'h01);

        // R3: rising edge latency
        stop_pin_i = 1;
        repeat (2) @(negedge clk); #1;
        check("R3 oe before latch", {7'b0, pad_oe_o}, 8'h01);
        @(negedge clk); #1;
        check("R3 oe off", {7'b0, pad_oe_o}, 8'h00);
        check("R7 wave still presented", {7'b0, pad_o}, 8'h01);

        // R4: hold through edges, mode change, write 1
        set_stop(0); set_stop(1);
        repeat (5) @(negedge clk); #1;
        check("R4 hold", {7'b0, pad_oe_o}, 8'h00);
        mode_ctl_i = 0; dir_i = 0; #1;
        check("R5 port over latch", {7'b0, pad_oe_o}, 8'h01);
        mode_ctl_i = 1; #1;
        check("R4 hold after mode", {7'b0, pad_oe_o}, 8'h00);
        ctl_write(1, 0, 8'h01); #1;
        check("R4 write1 keeps", {7'b0, pad_oe_o}, 8'h00);
        ctl_write(1, 0, 8'h00); #1;
        check("R4 cleared", {7'b0, pad_oe_o}, 8'h01);
        ctl_write(0, 0, 8'h01); #1;
        check("R10 re-enable no stop", {7'b0, pad_oe_o}, 8'h01);

        // R8: each edge-select code against both edge directions (stop now 1)
        set_stop(0);
        for (int c = 0; c < 4; c++) begin
            esel_write(2'(c));
            clear_stop(); #1;
            set_stop(1);
            check("R8 rise", {7'b0, pad_oe_o}, {7'b0, !(c == 1 || c == 3)});
            clear_stop(); #1;
            set_stop(0);
            check("R8 fall", {7'b0, pad_oe_o}, {7'b0, !(c == 0 || c == 3)});
        end
        clear_stop();

        // R9: protected edge-select write
        esel_write(2'b01);
        tmr_run_i = 1;
        esel_write(2'b11); #1;
        check("R9 esel kept", {6'b0, esel_o}, 8'h01);
        check("R9 err set", {7'b0, esel_err_o}, 8'h01);
        tmr_run_i = 0;
        esel_write(2'b00); #1;
        check("R9 esel idle write", {6'b0, esel_o}, 8'h00);
        check("R9 err sticky", {7'b0, esel_err_o}, 8'h01);

        // R10: edge outside timer mode does not latch
        esel_write(2'b01);
        mode_ctl_i = 1; func_ctl_i = 0;
        set_stop(1);
        func_ctl_i = 1; #1;
        check("R10 no latch in irq mode", {7'b0, pad_oe_o}, 8'h01);
        pad_i = 1; func_ctl_i = 0; #1;
        check("R6 irq follows pad", {7'b0, irq_o}, 8'h01);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule